// File: doc/BRIEF.md
# SPI Flash User-Transfer Engine

This block is a register-driven SPI master for serial NOR flash. Software fills a 64-byte buffer through 32-bit register writes and programs a bit count and a chip-select hold flag. It then writes a start command. The engine clocks the buffer out on MOSI. When full duplex is enabled, it writes the bits sampled on MISO back into the same buffer positions they were sent from, so received data replaces transmitted data in place. When the last bit has gone out, the engine raises a sticky done flag and drops its busy indication.

The serial clock rate is set outside the block. An SCK enable input marks each half period, and the engine changes SCK only in cycles where that input is high. Software cannot drive chip select directly. Each transfer either releases chip select at its end or keeps it asserted, so that a flash command can span several buffer loads.

Top module: `spi_xfer_top`

## Requirements
- R1: After reset, chip select is high (inactive), SCK and MOSI are low, and the status register at offset 0x30 reads zero.
- R2: The buffer occupies offsets 0x40 to 0x7C as sixteen 32-bit words. Byte 4w+k of the buffer sits in bits 8k+7..8k of word w. Writes to these words read back unchanged while the engine is idle.
- R3: A start writes 1 to bit 18 at offset 0x00. It shifts exactly N+1 bits, where N is the 9-bit field in bits 25..17 at offset 0x20. Buffer bytes go out in ascending order, MSB first within each byte. MOSI changes only while SCK is low, and SCK idles low (mode 0).
- R4: With bit 0 at offset 0x1C set, the MISO level at each rising SCK edge is written into the buffer bit that was sent in that same clock. Buffer bits beyond the N+1 shifted bits keep their value. With bit 0 clear, the buffer is not changed.
- R5: Bit 5 at offset 0x30 (busy) reads 1 from the cycle after a start until the transfer ends. Bit 4 (done) becomes 1 in the cycle after the last falling SCK edge and stays set. Writing 0 to bit 4 clears it.
- R6: Bit 30 at offset 0x2C selects what chip select does at the end of a transfer. If the bit is 1, chip select stays low; if it is 0, chip select is released. A start made while chip select is still held keeps it low, with no rising edge.
- R7: While busy, a start command and writes to the buffer words are ignored: no extra bits are shifted, and the buffer content is unchanged.
- R8: With bit 27 at offset 0x1C clear, MOSI stays low for the whole transfer. SCK still runs for all N+1 bits.
- R9: With bit 30 at offset 0x30 set (non-master mode), a start is ignored. Chip select stays high, and no SCK edge occurs.
- R10: Writing 1 to bit 31 at offset 0x30 aborts any transfer. In the next cycle chip select is high, SCK is low, and busy and done both read 0.
- R11: Chip select goes low at least one SCK enable pulse before the first rising SCK edge. SCK is high only while chip select is low. SCK changes only in cycles where the SCK enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Byte address for both writes and reads (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| sck_tick | input | 1 | SCK half-period enable |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Register read data is combinational, so every read is sampled in the same cycle it is addressed. A start write takes effect at one rising clock edge, and busy reads 1 in the cycle right after that edge. With the SCK enable held high for an N-bit transfer, the first rising SCK edge comes two cycles after the start edge. Done reads 0 after 2N edges and reads 1 after edge 2N+1. The bench samples at falling clock edges exactly at those counts. For slower SCK rates, the bench polls done and checks the content: edge counts, captured MOSI bits, buffer words and chip-select transitions. A model on falling edges supplies MISO and captures MOSI.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  localparam int OFS_CMD  = 'h00;
  localparam int OFS_MODE = 'h1c;
  localparam int OFS_LEN  = 'h20;
  localparam int OFS_CS   = 'h2c;
  localparam int OFS_STAT = 'h30;
  localparam int OFS_BUF  = 'h40;

  localparam int START_BIT  = 18;
  localparam int DUPLEX_BIT = 0;
  localparam int DOUT_BIT   = 27;
  localparam int LEN_LSB    = 17;
  localparam int HOLD_BIT   = 30;
  localparam int DONE_BIT   = 4;
  localparam int BUSY_BIT   = 5;
  localparam int MODE_BIT   = 30;
  localparam int SRST_BIT   = 31;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN
  } shift_st_e;

  // bit position inside a byte for serial index low bits: MSB goes first
  function automatic logic [2:0] lane_of(input logic [2:0] low);
    return 3'd7 - low;
  endfunction

endpackage

// File: rtl/spi_xfer_buf.sv
module spi_xfer_buf
  import spi_xfer_pkg::*;
#(
  parameter int BYTES = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [$clog2(BYTES/4)-1:0]         wr_word,
  input  logic [31:0]                        wr_data,
  input  logic [$clog2(BYTES/4)-1:0]         rd_word,
  output logic [31:0]                        rd_data,
  input  logic [$clog2(BYTES*8)-1:0]         tx_idx,
  output logic                               tx_bit,
  input  logic                               rx_we,
  input  logic [$clog2(BYTES*8)-1:0]         rx_idx,
  input  logic                               rx_bit
);
  localparam int IDX_W = $clog2(BYTES*8);

  logic [BYTES-1:0][7:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      if (wr_en) begin
        for (int k = 0; k < 4; k++) begin
          mem_q[{wr_word, 2'(k)}] <= wr_data[8*k +: 8];
        end
      end
      if (rx_we) begin
        mem_q[rx_idx[IDX_W-1:3]][lane_of(rx_idx[2:0])] <= rx_bit;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      rd_data[8*k +: 8] = mem_q[{rd_word, 2'(k)}];
    end
  end

  assign tx_bit = mem_q[tx_idx[IDX_W-1:3]][lane_of(tx_idx[2:0])];

  // host writes and shift capture never overlap
  assert_no_host_write_in_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rx_we);

endmodule

// File: rtl/spi_xfer_shift.sv
module spi_xfer_shift
  import spi_xfer_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic             tick,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             hold,
  input  logic             duplex,
  input  logic             dout_en,
  input  logic             tx_bit,
  input  logic             miso,
  output logic [IDX_W-1:0] tx_idx,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_idx,
  output logic             rx_bit,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  output logic             busy,
  output logic             done_evt
);
  shift_st_e        st_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             sck_q, mosi_q, cs_n_q, hold_q, duplex_q, dout_q;

  logic rise_evt, fall_evt;
  assign rise_evt = (st_q == ST_RUN) && tick && !sck_q;
  assign fall_evt = (st_q == ST_RUN) && tick && sck_q;
  assign done_evt = fall_evt && (idx_q == last_q);
  assign busy     = (st_q != ST_IDLE);

  assign tx_idx = (st_q == ST_IDLE) ? '0 : idx_q + 1'b1;
  assign rx_we  = rise_evt && duplex_q;
  assign rx_idx = idx_q;
  assign rx_bit = miso;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; last_q <= '0;
      sck_q <= 1'b0; mosi_q <= 1'b0; cs_n_q <= 1'b1;
      hold_q <= 1'b0; duplex_q <= 1'b0; dout_q <= 1'b0;
    end else if (abort) begin
      st_q <= ST_IDLE; idx_q <= '0;
      sck_q <= 1'b0; mosi_q <= 1'b0; cs_n_q <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q     <= ST_LEAD;
            idx_q    <= '0;
            cs_n_q   <= 1'b0;
            last_q   <= last_idx;
            hold_q   <= hold;
            duplex_q <= duplex;
            dout_q   <= dout_en;
            mosi_q   <= dout_en & tx_bit;
          end
        end
        ST_LEAD: begin
          if (tick) st_q <= ST_RUN;
        end
        default: begin
          if (rise_evt) sck_q <= 1'b1;
          if (fall_evt) begin
            sck_q <= 1'b0;
            if (idx_q == last_q) begin
              st_q   <= ST_IDLE;
              cs_n_q <= !hold_q;
              mosi_q <= 1'b0;
            end else begin
              idx_q  <= idx_q + 1'b1;
              mosi_q <= dout_q & tx_bit;
            end
          end
        end
      endcase
    end
  end

  assign sck  = sck_q;
  assign mosi = mosi_q;
  assign cs_n = cs_n_q;

  assert_sck_moves_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !abort) |=> $stable(sck_q));
  assert_cs_during_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> !cs_n_q);
  assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= last_q));
  assert_release_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !hold_q && !abort) |=> cs_n_q);
  assert_hold_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && hold_q && !abort) |=> !cs_n_q);
  assert_cfg_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt && !abort) |=> $stable(last_q));

endmodule

// File: rtl/spi_xfer_top.sv
module spi_xfer_top
  import spi_xfer_pkg::*;
#(
  parameter int BUF_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [6:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sck_tick,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int BUF_BITS = BUF_BYTES * 8;
  localparam int IDX_W    = $clog2(BUF_BITS);
  localparam int WORD_W   = $clog2(BUF_BYTES / 4);
  localparam int ADDR_W   = 7;

  logic wr_cmd, wr_mode, wr_len, wr_cs, wr_stat, in_buf;
  assign in_buf  = reg_addr >= ADDR_W'(OFS_BUF);
  assign wr_cmd  = reg_wr && reg_addr == ADDR_W'(OFS_CMD);
  assign wr_mode = reg_wr && reg_addr == ADDR_W'(OFS_MODE);
  assign wr_len  = reg_wr && reg_addr == ADDR_W'(OFS_LEN);
  assign wr_cs   = reg_wr && reg_addr == ADDR_W'(OFS_CS);
  assign wr_stat = reg_wr && reg_addr == ADDR_W'(OFS_STAT);

  logic             dout_q, duplex_q, hold_q, mode_q, done_q;
  logic [IDX_W-1:0] len_q;

  logic             busy, done_evt, abort, start_go, buf_we;
  logic [IDX_W-1:0] tx_idx, rx_idx;
  logic             tx_bit, rx_we, rx_bit;
  logic [31:0]      buf_rdata;

  assign abort    = wr_stat && reg_wdata[SRST_BIT];
  assign start_go = wr_cmd && reg_wdata[START_BIT] && !busy && !mode_q;
  assign buf_we   = reg_wr && in_buf && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 1'b0; duplex_q <= 1'b0; hold_q <= 1'b0;
      mode_q <= 1'b0; done_q <= 1'b0; len_q <= '0;
    end else begin
      if (wr_mode) begin
        dout_q   <= reg_wdata[DOUT_BIT];
        duplex_q <= reg_wdata[DUPLEX_BIT];
      end
      if (wr_len) len_q  <= reg_wdata[LEN_LSB +: IDX_W];
      if (wr_cs)  hold_q <= reg_wdata[HOLD_BIT];
      if (wr_stat) begin
        mode_q <= reg_wdata[MODE_BIT];
        done_q <= done_q & reg_wdata[DONE_BIT] & !abort;
      end
      if (done_evt && !abort) done_q <= 1'b1;
    end
  end

  spi_xfer_buf #(.BYTES(BUF_BYTES)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_we),
    .wr_word (reg_addr[WORD_W+1:2]),
    .wr_data (reg_wdata),
    .rd_word (reg_addr[WORD_W+1:2]),
    .rd_data (buf_rdata),
    .tx_idx  (tx_idx),
    .tx_bit  (tx_bit),
    .rx_we   (rx_we),
    .rx_idx  (rx_idx),
    .rx_bit  (rx_bit)
  );

  spi_xfer_shift #(.IDX_W(IDX_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (abort),
    .start    (start_go),
    .tick     (sck_tick),
    .last_idx (len_q),
    .hold     (hold_q),
    .duplex   (duplex_q),
    .dout_en  (dout_q),
    .tx_bit   (tx_bit),
    .miso     (spi_miso),
    .tx_idx   (tx_idx),
    .rx_we    (rx_we),
    .rx_idx   (rx_idx),
    .rx_bit   (rx_bit),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .cs_n     (spi_cs_n),
    .busy     (busy),
    .done_evt (done_evt)
  );

  always_comb begin
    reg_rdata = '0;
    if (in_buf) begin
      reg_rdata = buf_rdata;
    end else begin
      case (reg_addr)
        ADDR_W'(OFS_MODE): begin
          reg_rdata[DOUT_BIT]   = dout_q;
          reg_rdata[DUPLEX_BIT] = duplex_q;
        end
        ADDR_W'(OFS_LEN):  reg_rdata[LEN_LSB +: IDX_W] = len_q;
        ADDR_W'(OFS_CS):   reg_rdata[HOLD_BIT] = hold_q;
        ADDR_W'(OFS_STAT): begin
          reg_rdata[MODE_BIT] = mode_q;
          reg_rdata[BUSY_BIT] = busy;
          reg_rdata[DONE_BIT] = done_q;
        end
        default: ;
      endcase
    end
  end

  assert_srst_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && spi_cs_n && !done_q && !spi_sck));
  assert_done_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !abort) |=> (done_q && !busy));
  assert_mode_blocks_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !busy) |=> !busy);

endmodule

// File: tb/tb_spi_xfer_top.sv
module tb_spi_xfer_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck_tick = 1'b0;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0;
  int errors = 0;

  spi_xfer_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_tick(sck_tick),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // SCK enable generator
  int div = 1;
  int divc = 0;
  always @(negedge clk) begin
    if (divc + 1 >= div) begin sck_tick = 1'b1; divc = 0; end
    else begin sck_tick = 1'b0; divc = divc + 1; end
  end

  // flash-side model and monitor, sampled on falling clock edges
  logic [7:0] rxb [64];
  logic [7:0] tbuf [64];
  logic       cap [512];
  logic [8:0] slv_cnt = '0;
  int   cap_cnt = 0;
  int   cs_rises = 0;
  int   cs_bad = 0;
  int   cyc = 0;
  int   cs_fall_cyc = 0;
  int   first_lead = 0;
  logic prev_sck = 1'b0;
  logic prev_cs = 1'b1;

  assign spi_miso = rxb[slv_cnt[8:3]][3'd7 - slv_cnt[2:0]];

  always @(negedge clk) begin
    if (!prev_sck && spi_sck) begin
      if (cap_cnt < 512) cap[cap_cnt] = spi_mosi;
      if (cap_cnt == 0) first_lead = cyc - cs_fall_cyc;
      cap_cnt = cap_cnt + 1;
      if (spi_cs_n) cs_bad = cs_bad + 1;
    end
    if (prev_sck && !spi_sck) slv_cnt = slv_cnt + 1'b1;
    if (prev_cs && !spi_cs_n) cs_fall_cyc = cyc;
    if (!prev_cs && spi_cs_n) begin cs_rises = cs_rises + 1; slv_cnt = '0; end
    prev_sck = spi_sck;
    prev_cs  = spi_cs_n;
    cyc = cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 7'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    reg_addr = 7'(a);
    #1;
    d = reg_rdata;
  endtask

  function automatic logic tb_bit(input int i);
    return tbuf[i/8][7 - (i%8)];
  endfunction

  function automatic logic [31:0] exp_word(input int w);
    return {tbuf[4*w+3], tbuf[4*w+2], tbuf[4*w+1], tbuf[4*w]};
  endfunction

  task automatic fill_buf();
    for (int w = 0; w < 16; w++) begin
      logic [31:0] d;
      d = $urandom;
      wr_reg('h40 + 4*w, d);
      for (int k = 0; k < 4; k++) tbuf[4*w+k] = d[8*k +: 8];
    end
  endtask

  task automatic check_buf(input string tag);
    int bad = 0;
    logic [31:0] d, fd, fe;
    fd = '0; fe = '0;
    for (int w = 0; w < 16; w++) begin
      rd_reg('h40 + 4*w, d);
      if (d !== exp_word(w)) begin
        if (bad == 0) begin fd = d; fe = exp_word(w); end
        bad++;
      end
    end
    chk(bad == 0, tag, fd, fe);
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] s;
    int n = 0;
    rd_reg('h30, s);
    while (!s[4] && n < 20000) begin
      @(negedge clk);
      rd_reg('h30, s);
      n++;
    end
    chk(s[4] === 1'b1 && s[5] === 1'b0, tag, s, 32'h10);
  endtask

  task automatic setup(input int nbits, input bit dup, input bit dout, input bit hold, input int dv);
    div = dv;
    wr_reg('h1c, (32'(dout) << 27) | 32'(dup));
    wr_reg('h20, 32'(nbits - 1) << 17);
    wr_reg('h2c, 32'(hold) << 30);
    wr_reg('h30, 32'h0);
    for (int i = 0; i < 64; i++) rxb[i] = 8'($urandom);
    cap_cnt = 0;
  endtask

  task automatic run_xfer(input int nbits, input bit dup, input bit dout, input bit hold, input int dv);
    int mism = 0;
    setup(nbits, dup, dout, hold, dv);
    wr_reg('h00, 32'h1 << 18);
    wait_done("R5 done after transfer");
    chk(cap_cnt == nbits, "R3 rising edge count", 32'(cap_cnt), 32'(nbits));
    for (int i = 0; i < nbits; i++)
      if (cap[i] !== (tb_bit(i) & dout)) mism++;
    chk(mism == 0, dout ? "R3 MOSI bit order" : "R8 MOSI held low", 32'(mism), 32'h0);
    if (dup)
      for (int i = 0; i < nbits; i++) tbuf[i/8][7 - (i%8)] = rxb[i/8][7 - (i%8)];
    check_buf(dup ? "R4 duplex capture in place" : "R4 buffer kept without duplex");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors = errors + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s, d;
    int c0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin rxb[i] = '0; tbuf[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg('h30, s);
    chk(s == 32'h0, "R1 status after reset", s, 32'h0);
    chk({spi_cs_n, spi_sck, spi_mosi} == 3'b100, "R1 pins after reset",
        32'({spi_cs_n, spi_sck, spi_mosi}), 32'h4);

    // R2 buffer packing
    fill_buf();
    check_buf("R2 word readback");

    // R5 exact latency, R11 lead, SCK enable every cycle, 24 bits
    setup(24, 1'b0, 1'b1, 1'b0, 1);
    @(negedge clk);
    reg_addr = 7'h00; reg_wdata = 32'h1 << 18; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd_reg('h30, s);
    chk(s[5] === 1'b1, "R5 busy one cycle after start", s, 32'h20);
    repeat (48) @(negedge clk);
    rd_reg('h30, s);
    chk(s[4] === 1'b0 && s[5] === 1'b1, "R5 not done before last fall", s, 32'h20);
    @(negedge clk);
    rd_reg('h30, s);
    chk(s[4] === 1'b1 && s[5] === 1'b0, "R5 done after last fall", s, 32'h10);
    chk(first_lead == 2, "R11 CS lead before first SCK", 32'(first_lead), 32'd2);
    chk(cap_cnt == 24, "R3 bit count exact", 32'(cap_cnt), 32'd24);
    wr_reg('h30, 32'h0);
    rd_reg('h30, s);
    chk(s[4] === 1'b0, "R5 done cleared by writing 0", s, 32'h0);

    // random transfers
    for (int it = 0; it < 8; it++) begin
      int nb;
      nb = (it % 2 == 0) ? 8 * (1 + int'($urandom % 64)) : 1 + int'($urandom % 512);
      fill_buf();
      run_xfer(nb, 1'($urandom), 1'b1, 1'b0, 1 + int'($urandom % 4));
    end

    // corner: full 64 bytes, partial 12 bits, single bit
    fill_buf();
    run_xfer(512, 1'b1, 1'b1, 1'b0, 2);
    run_xfer(12, 1'b1, 1'b1, 1'b0, 1);
    run_xfer(1, 1'b1, 1'b1, 1'b0, 3);

    // R8 data-out stage disabled
    run_xfer(40, 1'b0, 1'b0, 1'b0, 2);

    // R6 hold chip select across two transfers
    c0 = cs_rises;
    run_xfer(16, 1'b0, 1'b1, 1'b1, 2);
    chk(spi_cs_n === 1'b0, "R6 CS held after transfer", 32'(spi_cs_n), 32'h0);
    run_xfer(8, 1'b0, 1'b1, 1'b0, 2);
    chk(cs_rises == c0 + 1, "R6 no CS release between held transfers", 32'(cs_rises), 32'(c0 + 1));
    chk(spi_cs_n === 1'b1, "R6 CS released at end", 32'(spi_cs_n), 32'h1);
    chk(cs_bad == 0, "R11 SCK high only with CS low", 32'(cs_bad), 32'h0);

    // R7 start and buffer write ignored while busy
    setup(64, 1'b0, 1'b1, 1'b0, 3);
    wr_reg('h00, 32'h1 << 18);
    wr_reg('h40, 32'hdeadbeef);
    wr_reg('h00, 32'h1 << 18);
    wait_done("R7 done with ignored start");
    repeat (30) @(negedge clk);
    chk(cap_cnt == 64, "R7 start ignored while busy", 32'(cap_cnt), 32'd64);
    rd_reg('h40, d);
    chk(d === exp_word(0), "R7 buffer write ignored while busy", d, exp_word(0));

    // R9 non-master mode blocks start
    wr_reg('h30, 32'h1 << 30);
    cap_cnt = 0;
    wr_reg('h00, 32'h1 << 18);
    repeat (20) @(negedge clk);
    rd_reg('h30, s);
    chk(s[5] === 1'b0 && cap_cnt == 0 && spi_cs_n === 1'b1, "R9 start ignored in non-master mode",
        s, 32'h40000000);
    wr_reg('h30, 32'h0);

    // R10 soft reset mid-transfer
    setup(512, 1'b0, 1'b1, 1'b0, 4);
    wr_reg('h00, 32'h1 << 18);
    repeat (50) @(negedge clk);
    wr_reg('h30, 32'h1 << 31);
    rd_reg('h30, s);
    chk(s == 32'h0, "R10 status after soft reset", s, 32'h0);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R10 pins after soft reset",
        32'({spi_cs_n, spi_sck}), 32'h2);
    c0 = cap_cnt;
    repeat (40) @(negedge clk);
    chk(cap_cnt == c0, "R10 no SCK after abort", 32'(cap_cnt), 32'(c0));

    // engine usable after abort
    run_xfer(32, 1'b1, 1'b1, 1'b0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule